// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block is a two-stage multiply-accumulate datapath built around a 32-bit accumulator and an 8-bit status register. Each request supplies two source words. The request says whether the full 32-bit words are used or a 16-bit half of each, and each half is chosen on its own. The two operands are multiplied. The product may be shifted by one bit either way. It is then added to or subtracted from the accumulator. The status register selects the number format (signed integer, unsigned integer or signed fraction), rounding and saturation, and it holds the negative, zero and sticky overflow flags.

A host loads the accumulator and the status register through dedicated write ports and reads both at any time. Results appear a fixed two cycles after a request, and a new request can be issued on every cycle. The multiplier has no data-dependent iteration, so a request issued back-to-back accumulates onto the result of the one before it.

Top module: `mac_unit`

## Requirements
- R1: With `op_wide`=1 the whole 32-bit source words are used. With `op_wide`=0 each operand is one 16-bit half of its word: the upper half when its select (`op_a_hi`, `op_b_hi`) is 1 and the lower half when it is 0. That half is sign-extended in signed mode and zero-extended in unsigned mode.
- R2: Status bit 6 set with bit 4 clear multiplies the operands as unsigned integers. With both bits clear they are multiplied as signed integers. Status bit 4 set selects signed fractions: a 16-bit half is placed in the upper half of a 32-bit fraction, the product is doubled, and its upper 32 bits form the addend. Bit 4 overrides bit 6.
- R3: `op_shift` encodes 2'b00 = no shift, 2'b01 = product shifted left one bit, 2'b10 = product shifted right one bit arithmetically, and 2'b11 = no shift.
- R4: `op_sub`=0 adds the product to the accumulator and `op_sub`=1 subtracts it.
- R5: In fractional mode, status bit 5 set rounds the addend to nearest by adding 2^31 before the low 32 bits are dropped. With bit 5 clear those bits are truncated.
- R6: With status bit 7 set, a result outside the accumulator's range is clamped. In signed and fractional modes the limits are 0x7FFFFFFF and 0x80000000. In unsigned mode they are 0xFFFFFFFF and 0.
- R7: With status bit 7 clear, an out-of-range result keeps its low 32 bits. Any out-of-range result sets overflow flag bit 1, which stays set until the status register is written.
- R8: After each accumulate, flag bit 3 (N) equals bit 31 of the new accumulator and flag bit 2 (Z) is set exactly when the new accumulator is zero.
- R9: `done` rises two clock edges after the edge that accepts a request, for one cycle per request. Requests on consecutive cycles complete on consecutive cycles, each one building on the result before it.
- R10: Reset clears the accumulator, the status register and `done`. `acc_wr` loads the accumulator. `sr_wr` loads status bits 7 to 1, and bit 0 always reads 0. A host write in the cycle an operation completes drops that operation's accumulator and flag update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request this cycle |
| op_src_a | input | 32 | First source word |
| op_src_b | input | 32 | Second source word |
| op_wide | input | 1 | 1 = 32-bit operands, 0 = 16-bit halves |
| op_a_hi | input | 1 | Half select for the first word (1 = upper) |
| op_b_hi | input | 1 | Half select for the second word (1 = upper) |
| op_shift | input | 2 | Product shift code |
| op_sub | input | 1 | 1 = subtract product, 0 = add |
| acc_wr | input | 1 | Accumulator write strobe |
| acc_wdata | input | 32 | Accumulator write value |
| acc_rdata | output | 32 | Current accumulator |
| sr_wr | input | 1 | Status register write strobe |
| sr_wdata | input | 7 | Status write value for bits 7 to 1 |
| sr_rdata | output | 8 | Status register: mode bits 7-4, N, Z, V, 0 |
| done | output | 1 | Operation result committed |

## Verification
The signed and unsigned runs use operand words whose chosen half has its top bit set, so only the extension rule decides the outcome. A half-select pair that mixes upper and lower shows that each operand picks its own half. Fractional cases use a small operand whose exact product sits at the rounding midpoint, so one pair of runs separates rounding from truncation. A negative odd operand under right shift tells an arithmetic shift from a logical one. Accumulator values just inside each limit, with and without saturation and in both signedness modes, separate clamping from wrapping. They also show that overflow stays set through a later clean operation. Back-to-back requests and a host write landing on a completion show how the two stages interleave.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  localparam int unsigned ACC_W  = 32;
  localparam int unsigned HALF_W = ACC_W / 2;
  localparam int unsigned PROD_W = 2 * ACC_W + 4;
  localparam int unsigned SUM_W  = PROD_W + 1;
  localparam int unsigned SR_W   = 8;
  localparam int unsigned NUM_OPS = 2;

  localparam int unsigned SR_SAT = 7;
  localparam int unsigned SR_UNS = 6;
  localparam int unsigned SR_RND = 5;
  localparam int unsigned SR_FRC = 4;
  localparam int unsigned SR_N   = 3;
  localparam int unsigned SR_Z   = 2;
  localparam int unsigned SR_V   = 1;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_HOLD  = 2'b11
  } shift_e;

  typedef struct packed {
    logic sat;
    logic uns;
    logic rnd;
    logic frc;
  } mode_t;

  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [SUM_W-1:0]  sum_t;
  typedef logic signed [ACC_W:0]    opnd_t;

  // Pick and widen one source operand into a signed (ACC_W+1)-bit value.
  function automatic opnd_t extend_operand(input logic [ACC_W-1:0] word,
                                           input logic wide,
                                           input logic hi,
                                           input logic as_unsigned,
                                           input logic frac);
    logic [HALF_W-1:0] half;
    half = hi ? word[ACC_W-1:HALF_W] : word[HALF_W-1:0];
    if (wide)
      return as_unsigned ? {1'b0, word} : {word[ACC_W-1], word};
    else if (frac)
      return {half[HALF_W-1], half, {HALF_W{1'b0}}};
    else if (as_unsigned)
      return {{(HALF_W+1){1'b0}}, half};
    else
      return {{(HALF_W+1){half[HALF_W-1]}}, half};
  endfunction

  // Multiply, align for fractions, apply the requested shift and rounding.
  function automatic prod_t form_product(input opnd_t a,
                                         input opnd_t b,
                                         input logic frac,
                                         input logic rnd,
                                         input logic [1:0] sh);
    prod_t pa;
    prod_t pb;
    prod_t p;
    pa = a;
    pb = b;
    p  = pa * pb;
    if (frac) p = p <<< 1;
    case (shift_e'(sh))
      SH_LEFT:  p = p <<< 1;
      SH_RIGHT: p = p >>> 1;
      default:  p = p;
    endcase
    if (frac) begin
      if (rnd) p = p + (prod_t'(1) <<< (ACC_W - 1));
      p = p >>> ACC_W;
    end
    return p;
  endfunction

  // Full-precision sum of accumulator and addend.
  function automatic sum_t wide_sum(input logic [ACC_W-1:0] acc,
                                    input prod_t addend,
                                    input logic sub,
                                    input logic uns);
    sum_t ax;
    sum_t ad;
    ax = {{(SUM_W-ACC_W){uns ? 1'b0 : acc[ACC_W-1]}}, acc};
    ad = addend;
    return sub ? (ax - ad) : (ax + ad);
  endfunction

  function automatic sum_t upper_limit(input logic uns);
    return uns ? ((sum_t'(1) <<< ACC_W) - sum_t'(1))
               : ((sum_t'(1) <<< (ACC_W - 1)) - sum_t'(1));
  endfunction

  function automatic sum_t lower_limit(input logic uns);
    return uns ? sum_t'(0) : -(sum_t'(1) <<< (ACC_W - 1));
  endfunction
endpackage

// File: rtl/mac_operand_sel.sv
`timescale 1ns/1ps
module mac_operand_sel
  import mac_pkg::*;
(
  input  logic [NUM_OPS-1:0][ACC_W-1:0] words,
  input  logic [NUM_OPS-1:0]            hi_sel,
  input  logic                          wide,
  input  logic                          as_unsigned,
  input  logic                          frac,
  output logic [NUM_OPS-1:0][ACC_W:0]   ext
);
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_opnd
    assign ext[g] = extend_operand(words[g], wide, hi_sel[g], as_unsigned, frac);
  end
endmodule

// File: rtl/mac_product.sv
`timescale 1ns/1ps
module mac_product
  import mac_pkg::*;
(
  input  logic [NUM_OPS-1:0][ACC_W:0] ext,
  input  logic                        frac,
  input  logic                        rnd,
  input  logic [1:0]                  shift,
  output prod_t                       addend
);
  assign addend = form_product($signed(ext[0]), $signed(ext[1]), frac, rnd, shift);
endmodule

// File: rtl/mac_accum.sv
`timescale 1ns/1ps
module mac_accum
  import mac_pkg::*;
(
  input  logic [ACC_W-1:0] acc,
  input  prod_t            addend,
  input  logic             sub,
  input  logic             uns,
  input  logic             sat,
  output logic [ACC_W-1:0] value,
  output logic             ovf
);
  sum_t total;
  sum_t hi_lim;
  sum_t lo_lim;
  logic above;
  logic below;

  assign total  = wide_sum(acc, addend, sub, uns);
  assign hi_lim = upper_limit(uns);
  assign lo_lim = lower_limit(uns);
  assign above  = total > hi_lim;
  assign below  = total < lo_lim;
  assign ovf    = above | below;

  always_comb begin
    if (sat && above)      value = hi_lim[ACC_W-1:0];
    else if (sat && below) value = lo_lim[ACC_W-1:0];
    else                   value = total[ACC_W-1:0];
  end
endmodule

// File: rtl/mac_unit.sv
`timescale 1ns/1ps
module mac_unit
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [ACC_W-1:0]  op_src_a,
  input  logic [ACC_W-1:0]  op_src_b,
  input  logic              op_wide,
  input  logic              op_a_hi,
  input  logic              op_b_hi,
  input  logic [1:0]        op_shift,
  input  logic              op_sub,
  input  logic              acc_wr,
  input  logic [ACC_W-1:0]  acc_wdata,
  output logic [ACC_W-1:0]  acc_rdata,
  input  logic              sr_wr,
  input  logic [SR_W-1:1]   sr_wdata,
  output logic [SR_W-1:0]   sr_rdata,
  output logic              done
);
  mode_t             mode_q;
  logic              n_q, z_q, v_q;
  logic [ACC_W-1:0]  acc_q;
  logic              done_q;

  // stage 1 registers
  logic              s1_valid;
  prod_t             s1_addend;
  logic              s1_sub;
  logic              s1_uns;
  logic              s1_sat;

  // named internal events
  logic              eff_uns;
  logic [NUM_OPS-1:0][ACC_W:0] ext;
  prod_t             addend;
  logic [ACC_W-1:0]  result_value;
  logic              result_ovf;
  logic              commit_evt;
  logic              ovf_evt;
  logic              sat_active;

  assign eff_uns = mode_q.uns & ~mode_q.frc;

  mac_operand_sel u_sel (
    .words       ({op_src_b, op_src_a}),
    .hi_sel      ({op_b_hi, op_a_hi}),
    .wide        (op_wide),
    .as_unsigned (eff_uns),
    .frac        (mode_q.frc),
    .ext         (ext)
  );

  mac_product u_prod (
    .ext    (ext),
    .frac   (mode_q.frc),
    .rnd    (mode_q.rnd),
    .shift  (op_shift),
    .addend (addend)
  );

  mac_accum u_acc (
    .acc    (acc_q),
    .addend (s1_addend),
    .sub    (s1_sub),
    .uns    (s1_uns),
    .sat    (s1_sat),
    .value  (result_value),
    .ovf    (result_ovf)
  );

  assign commit_evt = s1_valid & ~acc_wr & ~sr_wr;
  assign ovf_evt    = s1_valid & result_ovf;
  assign sat_active = s1_sat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_addend <= '0;
      s1_sub    <= 1'b0;
      s1_uns    <= 1'b0;
      s1_sat    <= 1'b0;
    end else begin
      s1_valid <= op_valid;
      if (op_valid) begin
        s1_addend <= addend;
        s1_sub    <= op_sub;
        s1_uns    <= eff_uns;
        s1_sat    <= mode_q.sat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mode_q <= '0;
      n_q    <= 1'b0;
      z_q    <= 1'b0;
      v_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= s1_valid;
      if (acc_wr)          acc_q <= acc_wdata;
      else if (commit_evt) acc_q <= result_value;
      if (sr_wr) begin
        mode_q <= mode_t'(sr_wdata[SR_W-1:SR_FRC]);
        n_q    <= sr_wdata[SR_N];
        z_q    <= sr_wdata[SR_Z];
        v_q    <= sr_wdata[SR_V];
      end else if (commit_evt) begin
        n_q <= result_value[ACC_W-1];
        z_q <= (result_value == '0);
        v_q <= v_q | result_ovf;
      end
    end
  end

  assign acc_rdata = acc_q;
  assign sr_rdata  = {mode_q, n_q, z_q, v_q, 1'b0};
  assign done      = done_q;
endmodule

// File: rtl/mac_unit_chk.sv
`timescale 1ns/1ps
module mac_unit_chk
  import mac_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             done,
  input logic             acc_wr,
  input logic             sr_wr,
  input logic             commit_evt,
  input logic             ovf_evt,
  input logic             sat_active,
  input logic [ACC_W-1:0] acc_rdata,
  input logic [SR_W-1:0]  sr_rdata
);
  a_r9_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> ##1 done);

  a_r9_done_has_request: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(op_valid, 2));

  a_r6_clamp_value: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && ovf_evt && sat_active) |=>
      ((&acc_rdata[ACC_W-2:0]) || !(|acc_rdata[ACC_W-2:0])));

  a_r7_overflow_sets_v: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && ovf_evt) |=> sr_rdata[SR_V]);

  a_r7_v_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rdata[SR_V] && !sr_wr) |=> sr_rdata[SR_V]);

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (sr_rdata[SR_Z] == (acc_rdata == '0)));

  a_r8_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (sr_rdata[SR_N] == acc_rdata[ACC_W-1]));

  a_r10_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sr_rdata[0] == 1'b0);

  a_r10_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_wr && !commit_evt) |=> $stable(acc_rdata));
endmodule

bind mac_unit mac_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .done       (done),
  .acc_wr     (acc_wr),
  .sr_wr      (sr_wr),
  .commit_evt (commit_evt),
  .ovf_evt    (ovf_evt),
  .sat_active (sat_active),
  .acc_rdata  (acc_rdata),
  .sr_rdata   (sr_rdata)
);

// File: tb/mac_unit_tb.sv
`timescale 1ns/1ps
module mac_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [31:0] op_src_a = '0;
  logic [31:0] op_src_b = '0;
  logic        op_wide = 1'b0;
  logic        op_a_hi = 1'b0;
  logic        op_b_hi = 1'b0;
  logic [1:0]  op_shift = 2'b00;
  logic        op_sub = 1'b0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        sr_wr = 1'b0;
  logic [7:1]  sr_wdata = '0;
  logic [7:0]  sr_rdata;
  logic        done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_src_a(op_src_a),
    .op_src_b(op_src_b), .op_wide(op_wide), .op_a_hi(op_a_hi), .op_b_hi(op_b_hi),
    .op_shift(op_shift), .op_sub(op_sub), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic put_sr(input logic [7:0] v);
    @(negedge clk); sr_wr = 1'b1; sr_wdata = v[7:1];
    @(negedge clk); sr_wr = 1'b0;
  endtask

  task automatic put_acc(input logic [31:0] v);
    @(negedge clk); acc_wr = 1'b1; acc_wdata = v;
    @(negedge clk); acc_wr = 1'b0;
  endtask

  task automatic drive_op(input logic [31:0] a, input logic [31:0] b, input logic wide,
                          input logic ahi, input logic bhi, input logic [1:0] sh,
                          input logic sub);
    op_valid = 1'b1; op_src_a = a; op_src_b = b; op_wide = wide;
    op_a_hi = ahi; op_b_hi = bhi; op_shift = sh; op_sub = sub;
  endtask

  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic wide, input logic ahi, input logic bhi,
                        input logic [1:0] sh, input logic sub,
                        input logic [31:0] exp_acc, input logic [7:0] exp_sr);
    @(negedge clk); drive_op(a, b, wide, ahi, bhi, sh, sub);
    @(negedge clk); op_valid = 1'b0;
    check("R9", "done one cycle after request", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R9", "done two cycles after request", {31'd0, done}, 32'd1);
    check(req, "accumulator", acc_rdata, exp_acc);
    check(req, "status", {24'd0, sr_rdata}, {24'd0, exp_sr});
  endtask

  task automatic t_reset;
    check("R10", "reset accumulator", acc_rdata, 32'd0);
    check("R10", "reset status", {24'd0, sr_rdata}, 32'd0);
    check("R10", "reset done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_signed_int;
    put_sr(8'h00); put_acc(32'd10);
    // R1 R2: -3 * 7 + 10 = -11, N set
    run_op("R2", 32'hFFFF_FFFD, 32'd7, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'hFFFF_FFF5, 8'h08);
  endtask

  task automatic t_halves;
    // R1: upper half 0xFFFF of a, lower half 0x0003 of b, unsigned
    put_sr(8'h40); put_acc(32'd5);
    run_op("R1", 32'hFFFF_0002, 32'h0007_0003, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0003_0002, 8'h40);
    // R1: same halves signed -> -1*3 + 5 = 2
    put_sr(8'h00); put_acc(32'd5);
    run_op("R1", 32'hFFFF_0002, 32'h0007_0003, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0000_0002, 8'h00);
  endtask

  task automatic t_fraction;
    // R2: 0.5 * 0.5 in 16-bit fractions -> 0.25 as Q31
    put_sr(8'h10); put_acc(32'd0);
    run_op("R2", 32'h0000_4000, 32'h4000_0000, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 32'h2000_0000, 8'h10);
    // R5: product exactly at the rounding midpoint, rounding on -> 1
    put_sr(8'h30); put_acc(32'd0);
    run_op("R5", 32'h0000_0001, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0000_0001, 8'h30);
    // R5 R8: rounding off truncates to 0, Z set
    put_sr(8'h10); put_acc(32'd0);
    run_op("R5", 32'h0000_0001, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0000_0000, 8'h14);
  endtask

  task automatic t_shift_sub;
    // R3: -7 shifted right arithmetically -> -4
    put_sr(8'h00); put_acc(32'd0);
    run_op("R3", 32'hFFFF_FFF9, 32'd1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 32'hFFFF_FFFC, 8'h08);
    // R3 R4: 100 - (3*5 << 1) = 70
    put_acc(32'd100);
    run_op("R4", 32'd3, 32'd5, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 32'd70, 8'h00);
    // R3: code 2'b11 leaves product unshifted -> 70 + 15 = 85
    run_op("R3", 32'd3, 32'd5, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 32'd85, 8'h00);
  endtask

  task automatic t_saturate;
    put_sr(8'h80); put_acc(32'h7FFF_FFF0);
    run_op("R6", 32'h0000_0100, 32'd1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h7FFF_FFFF, 8'h82);
    put_sr(8'h80); put_acc(32'h8000_0005);
    run_op("R6", 32'h0000_0010, 32'd1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 32'h8000_0000, 8'h8A);
    // R6: unsigned clamp at zero, Z and V set
    put_sr(8'hC0); put_acc(32'd5);
    run_op("R6", 32'd3, 32'd4, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 32'd0, 8'hC6);
  endtask

  task automatic t_wrap_sticky;
    put_sr(8'h00); put_acc(32'h7FFF_FFFF);
    run_op("R7", 32'd1, 32'd1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h8000_0000, 8'h0A);
    // R7: clean operation keeps V set
    run_op("R7", 32'd1, 32'd1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 32'h8000_0001, 8'h0A);
    put_sr(8'h00);
    check("R7", "status write clears V", {24'd0, sr_rdata}, 32'd0);
  endtask

  task automatic t_pipeline;
    put_sr(8'h00); put_acc(32'd0);
    @(negedge clk); drive_op(32'd2, 32'd3, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    @(negedge clk); drive_op(32'd4, 32'd5, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    @(negedge clk); op_valid = 1'b0;
    check("R9", "first of pair done", {31'd0, done}, 32'd1);
    check("R9", "first of pair result", acc_rdata, 32'd6);
    @(negedge clk);
    check("R9", "second of pair done", {31'd0, done}, 32'd1);
    check("R9", "second of pair result", acc_rdata, 32'd26);
    @(negedge clk);
    check("R9", "done drops after pair", {31'd0, done}, 32'd0);
  endtask

  task automatic t_host;
    put_sr(8'h00); put_acc(32'd0);
    @(negedge clk); drive_op(32'd2, 32'd3, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    @(negedge clk); op_valid = 1'b0; acc_wr = 1'b1; acc_wdata = 32'h0000_1234;
    @(negedge clk); acc_wr = 1'b0;
    check("R10", "colliding op still signals done", {31'd0, done}, 32'd1);
    check("R10", "host write wins", acc_rdata, 32'h0000_1234);
    check("R10", "flags untouched by dropped op", {24'd0, sr_rdata}, 32'd0);
    put_sr(8'hFF);
    check("R10", "bit 0 reads zero", {24'd0, sr_rdata}, 32'h0000_00FE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_signed_int;
    t_halves;
    t_fraction;
    t_shift_sub;
    t_saturate;
    t_wrap_sticky;
    t_pipeline;
    t_host;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule